// File: doc/BRIEF.md
# Translation Table Slot Probe and Update Unit

This block keeps a direct-mapped table of address translations in local storage. Each slot holds a tag word and a page table entry word. A probe takes a faulting virtual address and a context number. It picks the slot from the page-number bits, builds a comparison tag from the upper address bits and the context, and reads the slot in one registered cycle. It then returns either a hit together with the stored entry, or a miss. Instruction-side and data-side misses use the same table and the same probe port.

A separate update port installs a new tag and entry pair. The write is done under a lock bit held inside the tag word. Atomically with the read, the updater sets the lock on the slot's current tag. It then writes the entry, and finally writes the new tag, which also clears the lock. While the lock is set, any probe of that slot fails the compare, so a probe never returns a half-written slot. A tag of all zeros means the slot is empty. Every slot is cleared after reset.

Top module: `tsb_lookup`

## Requirements
- R1: After reset the unit clears every tag to zero, one slot per cycle. `req_ready` and `upd_ready` stay low until the SLOTS-th rising edge after reset release, and `rsp_valid` is low. Once the clearing is done, every probe misses.
- R2: The slot index is virtual address bits [21:13], and address bits [12:0] take no part in the probe. The comparison tag places context bits [12:0] at tag bits [60:48] and virtual address bits [63:22] at tag bits [41:0]. All other tag bits are zero.
- R3: A probe hits when the stored tag equals the built tag, the stored tag is nonzero and its lock bit is clear. On a hit, `rsp_pte` carries the stored entry. On a miss, `rsp_hit` is 0 and `rsp_pte` is 0.
- R4: An all-zero stored tag never hits, not even for a probe with context 0 and address bits [63:22] all zero.
- R5: Tag bit 47 is the lock bit. From the cycle the lock is installed until the final tag write, a probe of the slot being updated misses.
- R6: An accepted update locks the slot at the first edge after acceptance, writes the entry at the second and writes the tag at the third. `upd_ready` is low in between. A probe accepted after `upd_ready` returns high sees the new pair.
- R7: A probe and an update to the same slot in overlapping cycles yield either the old entry, a miss, or (after completion) the new entry. The new tag is never paired with the old entry.
- R8: `rsp_valid` rises the cycle after a probe is accepted. While `rsp_valid` is high and `rsp_ready` is low, the response holds steady and `req_ready` is low.
- R9: A probe whose context or address bits [63:22] differ from the stored tag misses. A later update that maps another address to the same slot replaces the earlier mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Probe request valid |
| req_ready | output | 1 | Probe request accepted when high |
| req_va | input | 64 | Faulting virtual address |
| req_ctx | input | 13 | Faulting context number |
| rsp_valid | output | 1 | Probe result valid |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_hit | output | 1 | 1 = hit, 0 = miss |
| rsp_pte | output | 64 | Stored page table entry on a hit, else 0 |
| upd_valid | input | 1 | Update request valid |
| upd_ready | output | 1 | Update port idle and accepting |
| upd_va | input | 64 | Virtual address to map |
| upd_ctx | input | 13 | Context of the new mapping |
| upd_pte | input | 64 | Page table entry to store |

## Verification
The probe path is driven with four kinds of input. The first is a full sweep that fills all 512 slots with distinct addresses, contexts and entries. Reading these back separates the index bits from the tag bits. Reading them back with the page-offset bits changed shows the offset is ignored, and reading them back with a neighbouring context shows the context takes part in the compare. A probe of address 0 in context 0 on freshly cleared slots separates "tag equals built tag" from "valid hit". A race pattern launches a probe at each cycle offset relative to an update that keeps the same tag but changes the entry. Only this pattern can reveal a new tag paired with an old entry. Finally, a held-response pattern and a same-slot replacement cover backpressure and conflict eviction.

// File: rtl/tsb_lookup.sv
module tsb_lookup #(
  parameter int SLOTS      = 512,
  parameter int PAGE_SHIFT = 13,
  parameter int VA_W       = 64,
  parameter int CTX_W      = 13,
  parameter int PTE_W      = 64,
  parameter int TAG_W      = 64,
  parameter int CTX_LSB    = 48,
  parameter int LOCK_BIT   = 47
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic [CTX_W-1:0] req_ctx,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_hit,
  output logic [PTE_W-1:0] rsp_pte,
  input  logic             upd_valid,
  output logic             upd_ready,
  input  logic [VA_W-1:0]  upd_va,
  input  logic [CTX_W-1:0] upd_ctx,
  input  logic [PTE_W-1:0] upd_pte
);
  localparam int IDX_W     = $clog2(SLOTS);
  localparam int VA_HI_LSB = PAGE_SHIFT + IDX_W;
  localparam int VA_HI_W   = VA_W - VA_HI_LSB;
  localparam logic [TAG_W-1:0] LOCK_MASK = {{(TAG_W-1){1'b0}}, 1'b1} << LOCK_BIT;

  typedef enum logic [1:0] {U_IDLE, U_LOCK, U_DATA, U_TAG} ust_t;

  function automatic logic [TAG_W-1:0] mk_tag(input logic [VA_W-1:0] va,
                                               input logic [CTX_W-1:0] ctx);
    logic [TAG_W-1:0] t;
    t = '0;
    t[VA_HI_W-1:0]      = va[VA_W-1:VA_HI_LSB];
    t[CTX_LSB +: CTX_W] = ctx;
    return t;
  endfunction

  logic [TAG_W-1:0] tag_mem [SLOTS];
  logic [PTE_W-1:0] pte_mem [SLOTS];

  logic             clearing;
  logic [IDX_W-1:0] clr_idx;

  logic             rsp_v_q;
  logic [TAG_W-1:0] rd_tag_q, want_q;
  logic [PTE_W-1:0] rd_pte_q;

  ust_t             ust;
  logic [IDX_W-1:0] u_idx;
  logic [TAG_W-1:0] u_tag;
  logic [PTE_W-1:0] u_pte;

  wire [IDX_W-1:0] req_idx  = req_va[PAGE_SHIFT +: IDX_W];
  wire [TAG_W-1:0] cur_utag = tag_mem[u_idx];
  wire             req_acc  = req_valid && req_ready;
  wire             upd_acc  = upd_valid && upd_ready;
  wire             tag_ok   = (rd_tag_q == want_q) && (rd_tag_q != '0) && !rd_tag_q[LOCK_BIT];

  assign req_ready = !clearing && (!rsp_v_q || rsp_ready);
  assign upd_ready = !clearing && (ust == U_IDLE);
  assign rsp_valid = rsp_v_q;
  assign rsp_hit   = rsp_v_q && tag_ok;
  assign rsp_pte   = rsp_hit ? rd_pte_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clearing <= 1'b1;
      clr_idx  <= '0;
    end else if (clearing) begin
      clr_idx <= clr_idx + 1'b1;
      if (clr_idx == IDX_W'(SLOTS-1)) clearing <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (clearing) tag_mem[clr_idx] <= '0;
    else begin
      case (ust)
        U_LOCK:  if (!cur_utag[LOCK_BIT]) tag_mem[u_idx] <= cur_utag | LOCK_MASK;
        U_DATA:  pte_mem[u_idx] <= u_pte;
        U_TAG:   tag_mem[u_idx] <= u_tag;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q  <= 1'b0;
      rd_tag_q <= '0;
      want_q   <= '0;
      rd_pte_q <= '0;
    end else if (req_acc) begin
      rsp_v_q  <= 1'b1;
      rd_tag_q <= tag_mem[req_idx];
      rd_pte_q <= pte_mem[req_idx];
      want_q   <= mk_tag(req_va, req_ctx);
    end else if (rsp_ready) begin
      rsp_v_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ust   <= U_IDLE;
      u_idx <= '0;
      u_tag <= '0;
      u_pte <= '0;
    end else begin
      case (ust)
        U_IDLE: if (upd_acc) begin
          ust   <= U_LOCK;
          u_idx <= upd_va[PAGE_SHIFT +: IDX_W];
          u_tag <= mk_tag(upd_va, upd_ctx);
          u_pte <= upd_pte;
        end
        U_LOCK:  if (!cur_utag[LOCK_BIT]) ust <= U_DATA;
        U_DATA:  ust <= U_TAG;
        default: ust <= U_IDLE;
      endcase
    end
  end

  // R1
  clear_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clearing |-> (!req_ready && !upd_ready && !rsp_valid));

  // R8
  rsp_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_acc |=> rsp_valid);

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_pte)));

  // R5
  lock_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ust == U_DATA || ust == U_TAG) |-> tag_mem[u_idx][LOCK_BIT]);

  // R6
  upd_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ust == U_DATA) |=> (ust == U_TAG) ##1 (ust == U_IDLE));

  // R4
  zero_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rd_tag_q == '0) |-> !rsp_hit);
endmodule

// File: tb/tsb_lookup_tb_top.sv
`timescale 1ns/1ps
module tsb_lookup_tb_top;
  localparam int SLOTS = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, rsp_ready = 1, upd_valid = 0;
  logic [63:0] req_va = '0, upd_va = '0, upd_pte = '0;
  logic [12:0] req_ctx = '0, upd_ctx = '0;
  logic req_ready, rsp_valid, rsp_hit, upd_ready;
  logic [63:0] rsp_pte;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  tsb_lookup dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_ctx(req_ctx),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_pte(rsp_pte),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_va(upd_va), .upd_ctx(upd_ctx),
    .upd_pte(upd_pte));

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] s_va(input int i);
    logic [41:0] hi;
    hi = 42'(i * 32'h9E37 + 1);
    return {hi, 9'(i), 13'(i * 3)};
  endfunction
  function automatic logic [12:0] s_ctx(input int i);
    return 13'(i * 37 + 5);
  endfunction
  function automatic logic [63:0] s_pte(input int i);
    return {32'hA5A5_0000 | 32'(i), 32'(i * 32'h1234567)};
  endfunction

  task automatic do_upd(input logic [63:0] va, input logic [12:0] ctx, input logic [63:0] pte);
    @(negedge clk);
    upd_valid = 1; upd_va = va; upd_ctx = ctx; upd_pte = pte;
    @(negedge clk); upd_valid = 0;
    chk(!upd_ready, "R6 busy after accept", 64'(upd_ready), 0);
    @(negedge clk);
    chk(!upd_ready, "R6 busy lock", 64'(upd_ready), 0);
    @(negedge clk);
    chk(!upd_ready, "R6 busy data", 64'(upd_ready), 0);
    @(negedge clk);
    chk(upd_ready, "R6 idle after tag", 64'(upd_ready), 1);
  endtask

  task automatic probe(input logic [63:0] va, input logic [12:0] ctx, input bit exp_hit,
                       input logic [63:0] exp_pte, input string rq);
    @(negedge clk);
    chk(req_ready, {rq, " ready"}, 64'(req_ready), 1);
    req_valid = 1; req_va = va; req_ctx = ctx;
    @(negedge clk); req_valid = 0;
    chk(rsp_valid, {rq, " R8 valid"}, 64'(rsp_valid), 1);
    chk(rsp_hit == exp_hit, {rq, " hit"}, 64'(rsp_hit), 64'(exp_hit));
    chk(rsp_pte == exp_pte, {rq, " pte"}, rsp_pte, exp_pte);
  endtask

  task automatic race(input int k);
    logic [63:0] va = s_va(77);
    logic [63:0] pa = 64'hAAAA_0000_0000_0000 + 64'(k);
    logic [63:0] pb = 64'hBBBB_0000_0000_0000 + 64'(k);
    do_upd(va, 13'h0F0, pa);
    @(negedge clk);
    upd_valid = 1; upd_va = va; upd_ctx = 13'h0F0; upd_pte = pb;
    for (int j = 0; j < k; j++) begin
      @(negedge clk); upd_valid = 0;
    end
    req_valid = 1; req_va = va; req_ctx = 13'h0F0;
    @(negedge clk); req_valid = 0; upd_valid = 0;
    if (k <= 1) begin
      chk(rsp_hit && rsp_pte == pa, "R7 old entry", rsp_pte, pa);
    end else if (k <= 3) begin
      chk(!rsp_hit && rsp_pte == 0, "R5 R7 locked miss", rsp_pte, 0);
    end else begin
      chk(rsp_hit && rsp_pte == pb, "R7 new entry", rsp_pte, pb);
    end
    while (!upd_ready) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(!rsp_valid, "R1 rsp_valid in reset", 64'(rsp_valid), 0);
    rst_n = 1;
    chk(!req_ready && !upd_ready, "R1 blocked while clearing", 64'(req_ready), 0);
    n = 0;
    do begin @(negedge clk); n++; end while (!req_ready && n < 2000);
    chk(n == SLOTS, "R1 clear duration", 64'(n), 64'(SLOTS));
    chk(upd_ready, "R1 update ready", 64'(upd_ready), 1);

    probe(64'h0, 13'h0, 0, 0, "R4 zero tag");
    probe(64'h0000_0000_003F_E000, 13'h0, 0, 0, "R4 zero tag top slot");
    probe(s_va(9), s_ctx(9), 0, 0, "R1 empty");

    for (int i = 0; i < SLOTS; i++) do_upd(s_va(i), s_ctx(i), s_pte(i));
    for (int i = 0; i < SLOTS; i++) begin
      probe(s_va(i), s_ctx(i), 1, s_pte(i), "R3 sweep hit");
      probe(s_va(i) ^ 64'h1FFF, s_ctx(i), 1, s_pte(i), "R2 offset ignored");
      probe(s_va(i), s_ctx(i) ^ 13'h1, 0, 0, "R9 ctx mismatch");
    end
    probe(s_va(3) ^ (64'h1 << 22), s_ctx(3), 0, 0, "R9 va hi mismatch");
    probe(s_va(3) ^ (64'h1 << 63), s_ctx(3), 0, 0, "R2 va bit63 in tag");
    probe(s_va(3), s_ctx(3) ^ 13'h1000, 0, 0, "R2 ctx bit12 in tag");

    for (int k = 0; k <= 4; k++) race(k);

    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_va = s_va(10); req_ctx = s_ctx(10);
    @(negedge clk); req_valid = 0;
    for (int c = 0; c < 3; c++) begin
      chk(rsp_valid && rsp_hit && rsp_pte == s_pte(10), "R8 held", rsp_pte, s_pte(10));
      chk(!req_ready, "R8 no accept while held", 64'(req_ready), 0);
      @(negedge clk);
    end
    rsp_ready = 1;
    @(negedge clk);
    chk(!rsp_valid, "R8 consumed", 64'(rsp_valid), 0);

    do_upd(s_va(5) ^ (64'h5 << 30), s_ctx(5), 64'hC0FFEE);
    probe(s_va(5), s_ctx(5), 0, 0, "R9 evicted");
    probe(s_va(5) ^ (64'h5 << 30), s_ctx(5), 1, 64'hC0FFEE, "R9 replacement");
    probe(s_va(6), s_ctx(6), 1, s_pte(6), "R9 neighbour intact");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule